// File: doc/BRIEF.md
# Two-Processor Interrupt Bypass and Distribution Router

This block sits between two interrupt sources and the interrupt pins of two processors. One source is a legacy interrupt line that arrives from an older external interrupt controller. The other is an internal error source, built by merging a set of active-high error flags into one active-low, level-sensitive request. The merged request also appears on its own pin, so that a system without this router can send it to a different controller.

Two configuration bits decide how requests reach the processors. With the router disabled, both sources go straight to processor 0. With the router enabled and bypass mode set, which is the default after reset, the legacy line still goes straight to processor 0. The error source is then routed. With bypass mode cleared, both sources go through a routed stage. That stage applies a 4-bit priority per source. It hands each accepted request to exactly one processor, which keeps it until it acknowledges. The router plays no part in any vector fetch from the legacy controller.

Top module: `irq_route_top`

## Requirements
- R1: While reset is held, and after reset, the router is disabled, bypass mode is set and both priorities are 0. `cpu_int[0]` equals `legacy_irq` OR any error flag, and `cpu_int[1]` is 0.
- R2: While disabled, `cpu_int[0]` follows `legacy_irq` OR any error flag in the same cycle and `cpu_int[1]` is 0. `int_ack` has no effect, and no routed state survives: after re-enabling, nothing is in service.
- R3: While enabled with bypass set, `cpu_int[0]` goes high in the same cycle as `legacy_irq`, and the legacy source is never handed out by the routed stage.
- R4: While enabled with bypass clear, the legacy source is delivered only through the routed stage. It reaches a processor one clock after it is sampled high.
- R5: `err_out_n` is low exactly when at least one bit of `err_flags` is high, with no clock delay. The merged request is level-sensitive.
- R6: A source whose priority is 0 is never handed out by the routed stage.
- R7: When both sources are eligible in the same cycle, the one with the larger priority value is handed out first. A tie goes to the legacy source. At most one hand-out occurs per clock.
- R8: Each hand-out goes to exactly one processor that is not already serving. Each source keeps a round-robin pointer, initially processor 0, which moves to the other processor after every hand-out of that source. If the pointed processor is busy, the other free one is used.
- R9: A processor's routed interrupt, `cpu_int[p]`, stays high from hand-out until a cycle with `int_ack[p]` high. It drops on the following clock.
- R10: A source is not handed out while it is already in service. After its acknowledge, it is not handed out again until it has been sampled low at least once.
- R11: Configuration writes with `cfg_we` high take effect on the next clock. Address 0 holds the enable in bit 0 and bypass mode in bit 1. Address 1 holds the legacy priority and address 2 holds the error priority, each in bits 3:0. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | PRIO_W | Configuration write data |
| legacy_irq | input | 1 | Legacy controller interrupt, source 0, active high |
| err_flags | input | NUM_ERR | Active-high error conditions merged into the error source |
| int_ack | input | 2 | Per-processor acknowledge strobe |
| cpu_int | output | 2 | Interrupt pin of processor 0 (bit 0) and processor 1 (bit 1) |
| err_out_n | output | 1 | Merged error request, active low |

## Verification
The bench builds the block with the default parameter values: four error flags and 4-bit priorities. With four flags, single-bit, highest-bit and all-bits error patterns can be applied and compared against the merged pin. With 4-bit priorities, the bench can write distinct values, equal values and zero to each source, which reaches the larger-wins, tie-to-legacy and disabled-source cases. Every clock is compared against a behavioural model of bypass, round-robin hand-out, acknowledge and re-arm.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NPROC  = 2;
  localparam int NSRC   = 2;
  localparam int CFG_AW = 2;

  // configuration register decode
  typedef enum logic [CFG_AW-1:0] {
    CFG_CTRL     = 2'd0,
    CFG_PRIO_LEG = 2'd1,
    CFG_PRIO_ERR = 2'd2
  } cfg_addr_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [PRIO_W-1:0] wdata,
  output logic              en,
  output logic              pt,
  output logic [PRIO_W-1:0] prio_leg,
  output logic [PRIO_W-1:0] prio_err
);
  logic              en_q, en_d, pt_q, pt_d;
  logic [PRIO_W-1:0] pl_q, pl_d, pe_q, pe_d;

  always_comb begin
    en_d = en_q;
    pt_d = pt_q;
    pl_d = pl_q;
    pe_d = pe_q;
    if (we) begin
      case (addr)
        CFG_CTRL: begin
          en_d = wdata[0];
          pt_d = wdata[1];
        end
        CFG_PRIO_LEG: pl_d = wdata;
        CFG_PRIO_ERR: pe_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pt_q <= 1'b1;
      pl_q <= '0;
      pe_q <= '0;
    end else if (we) begin
      en_q <= en_d;
      pt_q <= pt_d;
      pl_q <= pl_d;
      pe_q <= pe_d;
    end
  end

  assign en       = en_q;
  assign pt       = pt_q;
  assign prio_leg = pl_q;
  assign prio_err = pe_q;
endmodule

// File: rtl/irq_err_merge.sv
module irq_err_merge #(
  parameter int NUM_ERR = 4
) (
  input  logic [NUM_ERR-1:0] flags,
  output logic               err_act,
  output logic               err_n
);
  logic [NUM_ERR:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_or
    assign chain[i+1] = chain[i] | flags[i];
  end

  assign err_act = chain[NUM_ERR];
  assign err_n   = ~chain[NUM_ERR];
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_route_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pt,
  input  logic [PRIO_W-1:0] prio_leg,
  input  logic [PRIO_W-1:0] prio_err,
  input  logic [NSRC-1:0]   req,
  input  logic [NPROC-1:0]  ack,
  output logic [NPROC-1:0]  svc,
  output logic [NPROC-1:0]  grant,
  output logic              gsrc
);
  logic [NPROC-1:0] svc_q, svc_d, ssrc_q, ssrc_d;
  logic [NSRC-1:0]  arm_q, arm_d, rr_q, rr_d;
  logic [NSRC-1:0]  busy, elig, ack_hit;
  logic             sel, pref;

  always_comb begin
    // which source each processor is serving
    busy[0]    = (svc_q[0] & ~ssrc_q[0]) | (svc_q[1] & ~ssrc_q[1]);
    busy[1]    = (svc_q[0] &  ssrc_q[0]) | (svc_q[1] &  ssrc_q[1]);
    ack_hit[0] = (ack[0] & svc_q[0] & ~ssrc_q[0]) | (ack[1] & svc_q[1] & ~ssrc_q[1]);
    ack_hit[1] = (ack[0] & svc_q[0] &  ssrc_q[0]) | (ack[1] & svc_q[1] &  ssrc_q[1]);

    elig[0] = req[0] & (prio_leg != '0) & arm_q[0] & ~busy[0] & ~pt;
    elig[1] = req[1] & (prio_err != '0) & arm_q[1] & ~busy[1];

    // larger priority wins, legacy wins a tie
    sel  = elig[1] & (~elig[0] | (prio_err > prio_leg));
    pref = rr_q[sel];

    grant = '0;
    if (|elig) begin
      if (!svc_q[pref])       grant[pref]  = 1'b1;
      else if (!svc_q[!pref]) grant[!pref] = 1'b1;
    end

    svc_d  = svc_q;
    ssrc_d = ssrc_q;
    rr_d   = rr_q;
    for (int p = 0; p < NPROC; p++) begin
      if (grant[p]) begin
        svc_d[p]  = 1'b1;
        ssrc_d[p] = sel;
      end else if (ack[p]) begin
        svc_d[p] = 1'b0;
      end
    end
    for (int s = 0; s < NSRC; s++)
      arm_d[s] = ack_hit[s] ? 1'b0 : (~req[s] | arm_q[s]);
    if (|grant) rr_d[sel] = grant[0];

    if (!en) begin
      svc_d  = '0;
      ssrc_d = '0;
      arm_d  = '1;
      rr_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q  <= '0;
      ssrc_q <= '0;
      arm_q  <= '1;
      rr_q   <= '0;
    end else begin
      svc_q  <= svc_d;
      ssrc_q <= ssrc_d;
      arm_q  <= arm_d;
      rr_q   <= rr_d;
    end
  end

  assign svc  = svc_q;
  assign gsrc = sel;
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_ERR = 4,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [PRIO_W-1:0]  cfg_wdata,
  input  logic               legacy_irq,
  input  logic [NUM_ERR-1:0] err_flags,
  input  logic [NPROC-1:0]   int_ack,
  output logic [NPROC-1:0]   cpu_int,
  output logic               err_out_n
);
  logic              rst_sync_n;
  logic              cfg_en, cfg_pt, err_act, gsrc;
  logic [PRIO_W-1:0] prio_leg, prio_err;
  logic [NPROC-1:0]  svc, grant;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irq_cfg_regs #(.PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .en(cfg_en), .pt(cfg_pt),
    .prio_leg(prio_leg), .prio_err(prio_err)
  );

  irq_err_merge #(.NUM_ERR(NUM_ERR)) u_err (
    .flags(err_flags), .err_act(err_act), .err_n(err_out_n)
  );

  irq_dispatch #(.PRIO_W(PRIO_W)) u_disp (
    .clk(clk), .rst_n(rst_sync_n), .en(cfg_en), .pt(cfg_pt),
    .prio_leg(prio_leg), .prio_err(prio_err),
    .req({err_act, legacy_irq}), .ack(int_ack),
    .svc(svc), .grant(grant), .gsrc(gsrc)
  );

  // bypass when disabled; legacy line direct to processor 0 in bypass mode
  assign cpu_int[0] = cfg_en ? (svc[0] | (cfg_pt & legacy_irq)) : (legacy_irq | err_act);
  assign cpu_int[1] = cfg_en & svc[1];
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int PRIO_W = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              en,
  input logic              pt,
  input logic              legacy_irq,
  input logic [PRIO_W-1:0] prio_leg,
  input logic [PRIO_W-1:0] prio_err,
  input logic [1:0]        svc,
  input logic [1:0]        grant,
  input logic              gsrc,
  input logic [1:0]        ack,
  input logic [1:0]        cpu_int
);
  // R2
  off_proc1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |-> (cpu_int[1] == 1'b0));

  // R3
  bypass_direct_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && pt && legacy_irq) |-> cpu_int[0]);

  // R3
  bypass_no_route_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pt && (|grant)) |-> gsrc);

  // R6
  zero_prio_leg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prio_leg == '0) |-> !((|grant) && !gsrc));

  // R6
  zero_prio_err_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (prio_err == '0) |-> !((|grant) && gsrc));

  // R8
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant));

  // R8
  free_target_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (grant & svc) == 2'b00);

  // R9
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && svc[0] && !ack[0]) |=> (svc[0] || !$past(en)));

  // R9
  hold1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && svc[1] && !ack[1]) |=> (svc[1] || !$past(en)));
endmodule

bind irq_route_top irq_route_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .en(cfg_en), .pt(cfg_pt),
  .legacy_irq(legacy_irq), .prio_leg(prio_leg), .prio_err(prio_err),
  .svc(svc), .grant(grant), .gsrc(gsrc), .ack(int_ack), .cpu_int(cpu_int)
);

// File: tb/test_irq_route_top.sv
module test_irq_route_top;
  localparam int NE = 4;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_addr;
  logic [PW-1:0] cfg_wdata;
  logic          legacy_irq;
  logic [NE-1:0] err_flags;
  logic [1:0]    int_ack;
  logic [1:0]    cpu_int;
  logic          err_out_n;

  always #4 clk = ~clk;

  irq_route_top #(.NUM_ERR(NE), .PRIO_W(PW)) i_irq_route_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .legacy_irq(legacy_irq), .err_flags(err_flags),
    .int_ack(int_ack), .cpu_int(cpu_int), .err_out_n(err_out_n)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string req_tag = "R1";
  bit    model_live = 0;

  // behavioural reference state
  bit m_en, m_pt;
  int m_prio[2];
  bit m_busy[2];
  int m_who[2];
  bit m_armed[2];
  int m_next[2];

  function automatic void model_reset();
    m_en = 0; m_pt = 1; m_prio[0] = 0; m_prio[1] = 0;
    for (int i = 0; i < 2; i++) begin
      m_busy[i] = 0; m_who[i] = 0; m_armed[i] = 1; m_next[i] = 0;
    end
  endfunction

  task automatic check_outputs();
    bit e0, e1, err;
    err = (err_flags != 0);
    if (!m_en) begin e0 = legacy_irq | err; e1 = 0; end
    else begin e0 = m_busy[0] | (m_pt & legacy_irq); e1 = m_busy[1]; end
    n_tests++;
    if (cpu_int !== {e1, e0}) begin
      n_fail++;
      $display("FAIL %s cpu_int actual=%b expected=%b at %0t", req_tag, cpu_int, {e1, e0}, $time);
    end
    n_tests++;
    if (err_out_n !== !err) begin
      n_fail++;
      $display("FAIL R5 err_out_n actual=%b expected=%b at %0t", err_out_n, !err, $time);
    end
  endtask

  task automatic model_advance();
    bit req[2];
    int best, tgt, pref;
    bit n_busy[2], n_armed[2];
    req[0] = legacy_irq;
    req[1] = (err_flags != 0);
    if (!m_en) begin
      for (int i = 0; i < 2; i++) begin
        m_busy[i] = 0; m_who[i] = 0; m_armed[i] = 1; m_next[i] = 0;
      end
    end else begin
      best = -1;
      for (int s = 0; s < 2; s++) begin
        bit inuse;
        inuse = (m_busy[0] && m_who[0] == s) || (m_busy[1] && m_who[1] == s);
        if (req[s] && m_prio[s] != 0 && m_armed[s] && !inuse && !(s == 0 && m_pt))
          if (best < 0 || m_prio[s] > m_prio[best]) best = s;
      end
      tgt = -1;
      if (best >= 0) begin
        pref = m_next[best];
        if (!m_busy[pref]) tgt = pref;
        else if (!m_busy[1-pref]) tgt = 1 - pref;
      end
      for (int s = 0; s < 2; s++) begin
        bit acked;
        acked = 0;
        for (int p = 0; p < 2; p++)
          if (int_ack[p] && m_busy[p] && m_who[p] == s) acked = 1;
        n_armed[s] = acked ? 0 : (!req[s] ? 1 : m_armed[s]);
      end
      for (int p = 0; p < 2; p++)
        n_busy[p] = (p == tgt) ? 1 : (int_ack[p] ? 0 : m_busy[p]);
      if (tgt >= 0) begin
        m_who[tgt] = best;
        m_next[best] = 1 - tgt;
      end
      for (int i = 0; i < 2; i++) begin
        m_busy[i] = n_busy[i]; m_armed[i] = n_armed[i];
      end
    end
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin m_en = cfg_wdata[0]; m_pt = cfg_wdata[1]; end
        2'd1: m_prio[0] = int'(cfg_wdata);
        2'd2: m_prio[1] = int'(cfg_wdata);
        default: ;
      endcase
    end
  endtask

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      #1;
      check_outputs();
      if (model_live) model_advance();
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [PW-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_we = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    legacy_irq = 0; err_flags = 0; int_ack = 0;
    model_reset();
    @(negedge clk);
    // R1: bypass to processor 0 while reset is held
    req_tag = "R1";
    cyc(2);
    legacy_irq = 1; cyc(2);
    legacy_irq = 0; err_flags = 4'b0100; cyc(2);
    err_flags = 0;
    rst_n = 1; model_live = 1;
    cyc(3);
    legacy_irq = 1; cyc(2); legacy_irq = 0;

    // R5: merged error pin under several flag patterns
    req_tag = "R5";
    err_flags = 4'b0001; cyc();
    err_flags = 4'b1000; cyc();
    err_flags = 4'b1111; cyc();
    err_flags = 4'b0000; cyc();

    // R2: disabled bypass, acknowledges have no effect
    req_tag = "R2";
    int_ack = 2'b11; legacy_irq = 1; cyc(2);
    legacy_irq = 0; err_flags = 4'b0010; cyc(2);
    err_flags = 0; int_ack = 0; cyc();

    // R11: configuration map, address 3 ignored
    req_tag = "R11";
    wr(2'd0, 4'b0011);
    wr(2'd1, 4'd5);
    wr(2'd2, 4'd3);
    wr(2'd3, 4'hF);
    cyc();

    // R3: legacy goes straight through in bypass mode
    req_tag = "R3";
    legacy_irq = 1; cyc(3);
    legacy_irq = 0; cyc(2);

    // R4: legacy routed once bypass is cleared
    req_tag = "R4";
    wr(2'd0, 4'b0001);
    legacy_irq = 1; cyc();
    req_tag = "R9"; cyc(3);
    req_tag = "R10";
    int_ack = 2'b01; cyc();
    int_ack = 0; cyc(3);
    legacy_irq = 0; cyc();
    req_tag = "R8";
    legacy_irq = 1; cyc(3);
    int_ack = 2'b10; cyc();
    int_ack = 0; legacy_irq = 0; cyc(2);

    // R7: both sources eligible together
    req_tag = "R7";
    legacy_irq = 1; err_flags = 4'b0001; cyc(4);
    int_ack = 2'b11; cyc();
    int_ack = 0; legacy_irq = 0; err_flags = 0; cyc();
    wr(2'd1, 4'd2); wr(2'd2, 4'd9);
    legacy_irq = 1; err_flags = 4'b0100; cyc(3);
    int_ack = 2'b11; cyc();
    int_ack = 0; legacy_irq = 0; err_flags = 0; cyc();
    wr(2'd1, 4'd6); wr(2'd2, 4'd6);
    legacy_irq = 1; err_flags = 4'b1000; cyc(3);
    int_ack = 2'b01; cyc();
    int_ack = 2'b10; cyc();
    int_ack = 0; legacy_irq = 0; err_flags = 0; cyc(2);

    // R8: error source alternates processors
    req_tag = "R8";
    for (int r = 0; r < 3; r++) begin
      err_flags = 4'b0010; cyc(2);
      int_ack = 2'b11; cyc();
      int_ack = 0; err_flags = 0; cyc();
    end
    // R8: preferred processor busy, fallback to the other one
    legacy_irq = 1; cyc(2);
    err_flags = 4'b0001; cyc(3);
    int_ack = 2'b11; cyc();
    int_ack = 0; legacy_irq = 0; err_flags = 0; cyc(2);

    // R6: zero priority blocks the routed path
    req_tag = "R6";
    wr(2'd2, 4'd0);
    err_flags = 4'b1111; cyc(4);
    err_flags = 0;
    wr(2'd1, 4'd0);
    legacy_irq = 1; cyc(3);
    legacy_irq = 0; cyc();

    // R2: disabling drops routed state
    req_tag = "R2";
    wr(2'd1, 4'd4);
    legacy_irq = 1; cyc(2);
    wr(2'd0, 4'b0000);
    cyc(2);
    legacy_irq = 0; cyc();
    wr(2'd0, 4'b0001);
    cyc(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule